// File: doc/BRIEF.md
# Module Clock and Idle Controller

This block is the per-module power-management controller that sits between a software-programmed mode field and a single peripheral or processor module. It lives in a clock domain that may go to sleep. It drives the module's functional-clock enable and its interface-connect signal. It runs an idle request/acknowledge handshake with the module. It also raises a stay-awake vote toward the clock-domain controller. Domain and power sequencing are outside the block and appear only as a `domainActive` status input.

The mode field selects one of three behaviours:
- **Forced on** keeps the domain awake and the module running.
- **Automatic** leaves the domain free to sleep. It parks the module, disconnected, while the domain is asleep.
- **Disabled** retires the module through an idle handshake. Clocks stay on until the module agrees to stop.

A wakeup request from the module, for example on an incoming interrupt, brings a disabled or idling module back to life even though the mode still reads disabled. All inputs are synchronous to one always-running controller clock and are sampled as levels every cycle. All outputs are registered.

Top module: `modclk_idle_ctrl`

## Requirements
- R1: After reset, `idleStatus` is 3 (fully disabled) and `clkEn`, `connect`, `idleReq`, `stayAwake` and `idleDonePulse` are all 0.
- R2: With mode 2 (forced on), `stayAwake` is 1 from the cycle after the mode is applied. Once `domainActive` is seen high, `clkEn` and `connect` rise on the next clock edge and `idleStatus` becomes 0.
- R3: With mode 1 (automatic), `stayAwake` stays 0. A running module is disconnected with clocks off (`idleStatus` = 2) one edge after `domainActive` falls. It is reconnected (`idleStatus` = 0) one edge after `domainActive` rises.
- R4: Writing mode 0 to a running module raises `idleReq` with `idleStatus` = 1 on the next edge, and `clkEn`/`connect` stay 1. One edge after `idleAck` is seen, `clkEn`, `connect` and `idleReq` are 0 and `idleStatus` is 3.
- R5: `idleDonePulse` is 1 for exactly one cycle, in the cycle the block enters the acknowledged-off state after a handshake. It stays 0 on any other path into `idleStatus` 3.
- R6: While `idleAck` stays low and no wakeup arrives, the block remains at `idleStatus` 1 with the module clocked and connected, however long that lasts.
- R7: With mode 0, a high `wakeReq` sets `stayAwake` on the next edge. If `domainActive` is high, the module returns to running (`idleStatus` 0, clocks on) one edge after `wakeReq` is seen, whether it was fully off or idling. When `wakeReq` drops, the idle handshake restarts.
- R8: Mode value 3 is reserved and behaves exactly as mode 0, including the idle handshake and no `stayAwake` vote.
- R9: Writing mode 0 while parked (`idleStatus` 2) moves straight to `idleStatus` 3 on the next edge without raising `idleReq`.
- R10: `idleStatus` encodes 0 = functional, 1 = transitioning (idle requested), 2 = idle with interface disconnected, 3 = fully disabled.
- R11: If the mode changes to 1 or 2 while idling, the idle request is withdrawn and the module is functional again (`idleStatus` 0) on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-running controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | Software mode: 0 disabled, 1 automatic, 2 forced on, 3 reserved (disabled) |
| domainActive | input | 1 | Clock domain is awake |
| idleAck | input | 1 | Module agrees to stop (level) |
| wakeReq | input | 1 | Module asks to be woken (level) |
| clkEn | output | 1 | Functional-clock enable for the module |
| connect | output | 1 | Module interface connected |
| idleReq | output | 1 | Idle request to the module |
| stayAwake | output | 1 | Vote to wake or keep awake the clock domain |
| idleStatus | output | 2 | Idle status field (encoding in R10) |
| idleDonePulse | output | 1 | One-cycle notice of handshake completion |

## Verification
On every cycle the assertions check the handshake invariants. A raised idle request always comes with a live clock and interface. Clocks are never removed out of the transitioning state without an acknowledge. The forced-on mode always produces the vote, and a functional status always means a clocked, connected module. Other properties can only be shown by the bench's scenarios: a wakeup aborting a pending disable, a long stall with no acknowledge, domain sleep/wake cycles in automatic mode, the reserved code acting as disabled, and the parked-to-off shortcut. The bench follows these sequences with a behavioural model compared on every clock.

// File: rtl/modclk_idle_pkg.sv
package modclk_idle_pkg;

  localparam int MODE_W = 2;
  localparam int STAT_W = 2;

  localparam logic [MODE_W-1:0] MODE_OFF  = 2'd0;
  localparam logic [MODE_W-1:0] MODE_AUTO = 2'd1;
  localparam logic [MODE_W-1:0] MODE_ON   = 2'd2;

  // Status codes double as controller states
  typedef enum logic [STAT_W-1:0] {
    ST_RUN    = 2'd0,
    ST_IDLING = 2'd1,
    ST_PARKED = 2'd2,
    ST_OFF    = 2'd3
  } ctrl_state_e;

  typedef struct packed {
    logic loadRun;
    logic loadIdling;
    logic loadParked;
    logic loadOff;
    logic idleDone;
    logic vote;
  } ctrl_strobe_t;

endpackage

// File: rtl/modclk_idle_fsm.sv
module modclk_idle_fsm
  import modclk_idle_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeSel,
  input  logic              domainActive,
  input  logic              idleAck,
  input  logic              wakeReq,
  output ctrl_strobe_t      strobe
);

  ctrl_state_e curState, nextState;
  logic [MODE_W-1:0] effMode;
  logic wantOff;

  // Reserved code folds onto disabled
  always_comb begin
    if (modeSel == MODE_ON || modeSel == MODE_AUTO) effMode = modeSel;
    else effMode = MODE_OFF;
  end

  assign wantOff = (effMode == MODE_OFF) && !wakeReq;

  always_comb begin
    nextState = curState;
    case (curState)
      ST_OFF: begin
        if (effMode == MODE_AUTO) nextState = domainActive ? ST_RUN : ST_PARKED;
        else if (!wantOff && domainActive) nextState = ST_RUN;
      end
      ST_RUN: begin
        if (wantOff) nextState = ST_IDLING;
        else if (effMode == MODE_AUTO && !domainActive) nextState = ST_PARKED;
      end
      ST_IDLING: begin
        if (!wantOff) nextState = ST_RUN;
        else if (idleAck) nextState = ST_OFF;
      end
      ST_PARKED: begin
        if (effMode == MODE_OFF) nextState = ST_OFF;
        else if (domainActive) nextState = ST_RUN;
      end
      default: nextState = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_OFF;
    else curState <= nextState;
  end

  always_comb begin
    strobe.loadRun    = (nextState == ST_RUN);
    strobe.loadIdling = (nextState == ST_IDLING);
    strobe.loadParked = (nextState == ST_PARKED);
    strobe.loadOff    = (nextState == ST_OFF);
    strobe.idleDone   = (curState == ST_IDLING) && (nextState == ST_OFF);
    strobe.vote       = (effMode == MODE_ON) || ((effMode == MODE_OFF) && wakeReq);
  end

endmodule

// File: rtl/modclk_idle_dp.sv
module modclk_idle_dp
  import modclk_idle_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  output logic              clkEn,
  output logic              connect,
  output logic              idleReq,
  output logic              stayAwake,
  output logic [STAT_W-1:0] idleStatus,
  output logic              idleDonePulse
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkEn         <= 1'b0;
      connect       <= 1'b0;
      idleReq       <= 1'b0;
      idleStatus    <= ST_OFF;
      stayAwake     <= 1'b0;
      idleDonePulse <= 1'b0;
    end else begin
      stayAwake     <= strobe.vote;
      idleDonePulse <= strobe.idleDone;
      if (strobe.loadRun) begin
        clkEn <= 1'b1; connect <= 1'b1; idleReq <= 1'b0; idleStatus <= ST_RUN;
      end else if (strobe.loadIdling) begin
        clkEn <= 1'b1; connect <= 1'b1; idleReq <= 1'b1; idleStatus <= ST_IDLING;
      end else if (strobe.loadParked) begin
        clkEn <= 1'b0; connect <= 1'b0; idleReq <= 1'b0; idleStatus <= ST_PARKED;
      end else if (strobe.loadOff) begin
        clkEn <= 1'b0; connect <= 1'b0; idleReq <= 1'b0; idleStatus <= ST_OFF;
      end
    end
  end

endmodule

// File: rtl/modclk_idle_ctrl.sv
module modclk_idle_ctrl
  import modclk_idle_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeSel,
  input  logic              domainActive,
  input  logic              idleAck,
  input  logic              wakeReq,
  output logic              clkEn,
  output logic              connect,
  output logic              idleReq,
  output logic              stayAwake,
  output logic [STAT_W-1:0] idleStatus,
  output logic              idleDonePulse
);

  ctrl_strobe_t strobe;

  modclk_idle_fsm u_fsm (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .domainActive(domainActive),
    .idleAck(idleAck), .wakeReq(wakeReq), .strobe(strobe)
  );

  modclk_idle_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .clkEn(clkEn), .connect(connect),
    .idleReq(idleReq), .stayAwake(stayAwake), .idleStatus(idleStatus),
    .idleDonePulse(idleDonePulse)
  );

endmodule

// File: rtl/modclk_idle_chk.sv
module modclk_idle_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] modeSel,
  input logic       idleAck,
  input logic       clkEn,
  input logic       connect,
  input logic       idleReq,
  input logic       stayAwake,
  input logic [1:0] idleStatus,
  input logic       idleDonePulse
);

  // R4
  req_has_clock_chk: assert property (@(posedge clk) disable iff (!rstN)
    idleReq |-> (clkEn && connect));

  // R4
  gate_needs_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(clkEn) && $past(idleReq)) |-> $past(idleAck));

  // R2
  forced_on_vote_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'd2) |=> stayAwake);

  // R5
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    idleDonePulse |=> !idleDonePulse);

  // R5
  pulse_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    idleDonePulse |-> (idleStatus == 2'd3 && $past(idleReq)));

  // R10
  functional_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idleStatus == 2'd0) |-> (clkEn && connect && !idleReq));

endmodule

bind modclk_idle_ctrl modclk_idle_chk u_chk (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .idleAck(idleAck),
  .clkEn(clkEn), .connect(connect), .idleReq(idleReq), .stayAwake(stayAwake),
  .idleStatus(idleStatus), .idleDonePulse(idleDonePulse)
);

// File: tb/modclk_idle_ctrl_bench.sv
module modclk_idle_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] modeSel = 2'd0;
  logic domainActive = 1'b0, idleAck = 1'b0, wakeReq = 1'b0;
  logic clkEn, connect, idleReq, stayAwake, idleDonePulse;
  logic [1:0] idleStatus;

  int tests = 0;
  int fails = 0;
  string curReq = "R1";

  // behavioural model state
  int mStatus = 3;
  bit mVote = 0;
  bit mPulse = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modclk_idle_ctrl u_modclk_idle_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .domainActive(domainActive),
    .idleAck(idleAck), .wakeReq(wakeReq), .clkEn(clkEn), .connect(connect),
    .idleReq(idleReq), .stayAwake(stayAwake), .idleStatus(idleStatus),
    .idleDonePulse(idleDonePulse)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mStatus <= 3; mVote <= 0; mPulse <= 0;
    end else begin : mdl
      int e;
      bit off;
      e = (modeSel == 2'd3) ? 0 : int'(modeSel);
      off = (e == 0) && !wakeReq;
      mVote <= (e == 2) || (e == 0 && wakeReq);
      mPulse <= 0;
      if (mStatus == 3) begin
        if (e == 1) mStatus <= domainActive ? 0 : 2;
        else if (!off && domainActive) mStatus <= 0;
      end else if (mStatus == 0) begin
        if (off) mStatus <= 1;
        else if (e == 1 && !domainActive) mStatus <= 2;
      end else if (mStatus == 1) begin
        if (!off) mStatus <= 0;
        else if (idleAck) begin mStatus <= 3; mPulse <= 1; end
      end else begin
        if (e == 0) mStatus <= 3;
        else if (domainActive) mStatus <= 0;
      end
    end
  end

  // cycle compare against the model
  always @(negedge clk) begin
    if (rstN) begin
      bit on;
      on = (mStatus <= 1);
      tests++;
      if (clkEn !== on || connect !== on || idleReq !== (mStatus == 1) ||
          idleStatus !== 2'(mStatus) || stayAwake !== mVote || idleDonePulse !== mPulse) begin
        fails++;
        $display("FAIL %s model: act clk=%b con=%b req=%b st=%0d vote=%b pls=%b exp clk=%b req=%b st=%0d vote=%b pls=%b",
                 curReq, clkEn, connect, idleReq, idleStatus, stayAwake, idleDonePulse,
                 on, mStatus == 1, mStatus, mVote, mPulse);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R1 status", idleStatus, 3);
    chk("R1 outputs", {clkEn, connect, idleReq, stayAwake, idleDonePulse}, 0);
    rstN = 1'b1;
    cyc(2);
    chk("R10 off code", idleStatus, 3);

    curReq = "R2";
    modeSel = 2'd2; cyc(1);
    chk("R2 vote", stayAwake, 1);
    chk("R2 waits for domain", clkEn, 0);
    domainActive = 1'b1; cyc(1);
    chk("R2 clock on", {clkEn, connect}, 3);
    chk("R2 functional", idleStatus, 0);

    curReq = "R4";
    modeSel = 2'd0; cyc(1);
    chk("R4 idle request", {idleReq, clkEn, connect}, 7);
    chk("R4 transitioning", idleStatus, 1);
    curReq = "R6";
    cyc(6);
    chk("R6 still transitioning", idleStatus, 1);
    chk("R6 clock kept", clkEn, 1);
    curReq = "R5";
    idleAck = 1'b1; cyc(1);
    chk("R4 off after ack", {clkEn, connect, idleReq}, 0);
    chk("R5 pulse", idleDonePulse, 1);
    idleAck = 1'b0; cyc(1);
    chk("R5 pulse one cycle", idleDonePulse, 0);

    curReq = "R7";
    domainActive = 1'b0; wakeReq = 1'b1; cyc(1);
    chk("R7 vote on wake", stayAwake, 1);
    chk("R7 waits for domain", idleStatus, 3);
    domainActive = 1'b1; cyc(1);
    chk("R7 running with mode 0", idleStatus, 0);
    wakeReq = 1'b0; cyc(1);
    chk("R7 handshake restarts", idleReq, 1);
    wakeReq = 1'b1; cyc(1);
    chk("R7 wake aborts idle", idleStatus, 0);
    wakeReq = 1'b0; cyc(1);
    idleAck = 1'b1; cyc(1);
    chk("R7 off again", idleStatus, 3);
    idleAck = 1'b0;

    curReq = "R3";
    modeSel = 2'd1; cyc(1);
    chk("R3 running", idleStatus, 0);
    chk("R3 no vote", stayAwake, 0);
    domainActive = 1'b0; cyc(1);
    chk("R3 parked", {idleStatus, clkEn, connect}, 8);
    domainActive = 1'b1; cyc(1);
    chk("R3 reconnected", {clkEn, connect}, 3);
    domainActive = 1'b0; cyc(2);
    domainActive = 1'b1; cyc(2);
    chk("R3 second wake", idleStatus, 0);

    curReq = "R11";
    modeSel = 2'd0; cyc(1);
    chk("R11 idling", idleStatus, 1);
    modeSel = 2'd1; cyc(1);
    chk("R11 back to run", {idleStatus, idleReq}, 0);

    curReq = "R9";
    domainActive = 1'b0; cyc(1);
    chk("R9 parked", idleStatus, 2);
    modeSel = 2'd0; cyc(1);
    chk("R9 direct off", idleStatus, 3);
    chk("R9 no request", idleReq, 0);
    chk("R5 no pulse on shortcut", idleDonePulse, 0);

    curReq = "R8";
    domainActive = 1'b1; modeSel = 2'd2; cyc(2);
    modeSel = 2'd3; cyc(1);
    chk("R8 reserved requests idle", idleStatus, 1);
    chk("R8 reserved no vote", stayAwake, 0);
    idleAck = 1'b1; cyc(1);
    chk("R8 reserved off", idleStatus, 3);
    idleAck = 1'b0; cyc(3);
    chk("R8 stays off", idleStatus, 3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule